// File: doc/BRIEF.md
# Command-Driven Memory Write Engine

This engine moves data from a source port into memory, one word per write beat. It takes one command at a time. A command carries a word-aligned destination word address, a byte count and a mode bit. After it accepts a command, the engine pulls data words from its source port and issues one memory write per word. The memory address starts at the commanded address and goes up by one word on each beat. The last word is written with byte enables that cover only the bytes still owed. The engine waits whenever the source has no data, and it holds a pending write until the memory accepts it.

The mode bit selects how the source is treated:

- **Buffered mode:** the source acts as a plain data FIFO. The end-of-packet flag is ignored, and the transfer always runs to the commanded count.
- **Stream mode:** the source acts as a packet stream. An end-of-packet flag that arrives before the count is used up ends the transfer at that word.

Once the final write has been accepted, the engine posts a one-cycle status. The status gives the number of bytes actually written, a short-transfer flag and an error flag. A command with a zero byte count writes nothing and posts an error.

Top module: `dma_wr_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1 and both `mem_valid` and `sts_valid` are 0.
- R2: `cmd_ready` is 0 from the cycle after a command is accepted until the status pulse has been posted. No second command is taken while a transfer is in progress.
- R3: The first write of a transfer goes to `cmd_addr`. Each following write goes to the previous address plus one.
- R4: Source words are written in arrival order, with the data unchanged. While the source shows no valid word, no new write is issued; the engine pauses and then resumes.
- R5: In buffered mode (`cmd_stream`=0), exactly ceil(bytes/NB) writes are issued, where NB = DW/8. `src_last` has no effect in this mode.
- R6: Every write except the last has all NB byte enables set. If the last word is partial, its enables are the low (bytes mod NB) bits, with bit i enabling data byte i.
- R7: In stream mode (`cmd_stream`=1), a word carrying `src_last`=1 is the last one written. The reported count is then min(bytes, words×NB), and `sts_short` is 1 exactly when that count is below the commanded bytes.
- R8: `sts_valid` is high for exactly one cycle: the cycle after the final write handshake. At that time `sts_bytes` holds the actual byte count.
- R9: A command with a byte count of 0 issues no writes. Its status arrives in the cycle after the command handshake, with `sts_err`=1, `sts_bytes`=0 and `sts_short`=0. All other transfers report `sts_err`=0.
- R10: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr`, `mem_data` and `mem_be` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_addr | input | AW | Destination word address |
| cmd_bytes | input | CW | Number of bytes to write |
| cmd_stream | input | 1 | 1: stream mode, end-of-packet honoured |
| src_valid | input | 1 | Source word available |
| src_ready | output | 1 | Engine takes the source word |
| src_data | input | DW | Source word |
| src_last | input | 1 | End of packet on this word |
| mem_valid | output | 1 | Write beat pending |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | AW | Write word address |
| mem_data | output | DW | Write data |
| mem_be | output | DW/8 | Byte enables |
| sts_valid | output | 1 | Completion pulse |
| sts_bytes | output | CW | Bytes actually written |
| sts_short | output | 1 | Stream ended before the count was met |
| sts_err | output | 1 | Zero-length command |

## Verification
A source word appears on the memory port one cycle after its source handshake. The status pulse comes one cycle after the final memory handshake, or one cycle after the command handshake for a zero-length command. The bench changes all inputs on the falling edge and lets them settle briefly. It then records which handshakes the next rising edge will complete, so every output is read at the point where it is due. Each beat is compared with the address, data and enables predicted from its beat index. The status pulse is checked against the cycle index of the handshake that should trigger it.

// File: rtl/dma_wr_engine.sv
module dma_wr_engine #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [CW-1:0] cmd_bytes,
  input  logic          cmd_stream,
  input  logic          src_valid,
  output logic          src_ready,
  input  logic [DW-1:0] src_data,
  input  logic          src_last,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic [DW/8-1:0] mem_be,
  output logic          sts_valid,
  output logic [CW-1:0] sts_bytes,
  output logic          sts_short,
  output logic          sts_err
);
  localparam int NB = DW / 8;
  localparam int BW = $clog2(NB + 1);

  typedef enum logic [1:0] {IDLE, XFER, DONE} state_t;
  state_t st;

  logic [AW-1:0] next_addr;
  logic [CW-1:0] rem, acc;
  logic          stream, last_loaded, err_q;
  logic [BW-1:0] take;
  logic [NB-1:0] be_mask;
  logic          pop, fire, last_beat;

  assign take      = (rem >= CW'(NB)) ? BW'(NB) : rem[BW-1:0];
  assign be_mask   = {NB{1'b1}} >> (BW'(NB) - take);
  assign cmd_ready = (st == IDLE);
  assign src_ready = (st == XFER) && !last_loaded && (!mem_valid || mem_ready);
  assign pop       = src_valid && src_ready;
  assign fire      = mem_valid && mem_ready;
  assign last_beat = (rem <= CW'(NB)) || (stream && src_last);

  assign sts_valid = (st == DONE);
  assign sts_bytes = acc;
  assign sts_err   = err_q;
  assign sts_short = (st == DONE) && !err_q && (rem != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= IDLE;
      next_addr   <= '0;
      rem         <= '0;
      acc         <= '0;
      stream      <= 1'b0;
      last_loaded <= 1'b0;
      err_q       <= 1'b0;
      mem_valid   <= 1'b0;
      mem_addr    <= '0;
      mem_data    <= '0;
      mem_be      <= '0;
    end else begin
      case (st)
        IDLE: if (cmd_valid) begin
          next_addr   <= cmd_addr;
          rem         <= cmd_bytes;
          acc         <= '0;
          stream      <= cmd_stream;
          last_loaded <= 1'b0;
          err_q       <= (cmd_bytes == '0);
          st          <= (cmd_bytes == '0) ? DONE : XFER;
        end
        XFER: begin
          if (fire) begin
            mem_valid <= 1'b0;
            if (last_loaded) st <= DONE;
          end
          if (pop) begin
            mem_valid   <= 1'b1;
            mem_addr    <= next_addr;
            mem_data    <= src_data;
            mem_be      <= be_mask;
            next_addr   <= next_addr + 1'b1;
            rem         <= rem - CW'(take);
            acc         <= acc + CW'(take);
            last_loaded <= last_beat;
          end
        end
        default: begin
          st    <= IDLE;
          err_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

module dma_wr_engine_chk #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic [DW/8-1:0] mem_be,
  input logic          sts_valid,
  input logic [CW-1:0] sts_bytes,
  input logic          sts_short,
  input logic          sts_err
);
  // R10
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));
  // R2
  busy_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !cmd_ready);
  // R2
  take_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  // R8
  sts_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |=> !sts_valid);
  // R9
  err_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_valid && sts_err) |-> (sts_bytes == '0 && !sts_short));
  // R8
  sts_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_valid && !sts_err) |-> $past(mem_valid && mem_ready));
endmodule

bind dma_wr_engine dma_wr_engine_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_data(mem_data), .mem_be(mem_be), .sts_valid(sts_valid),
  .sts_bytes(sts_bytes), .sts_short(sts_short), .sts_err(sts_err)
);

// File: tb/tb_dma_wr_engine.sv
`timescale 1ns/1ps
module tb_dma_wr_engine;
  localparam int AW = 16, DW = 32, CW = 12, NB = DW / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_stream = 1'b0, cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [CW-1:0] cmd_bytes = '0;
  logic src_valid = 1'b0, src_last = 1'b0, src_ready;
  logic [DW-1:0] src_data = '0;
  logic mem_valid, mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic [NB-1:0] mem_be;
  logic sts_valid, sts_short, sts_err;
  logic [CW-1:0] sts_bytes;

  int n_chk = 0, n_bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  dma_wr_engine #(.AW(AW), .DW(DW), .CW(CW)) dut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic run(input int addr, input int bytes, input bit strm, input int eop, input bit gaps);
    int words = (bytes + NB - 1) / NB;
    int supply = (strm && eop >= 0 && eop < words) ? eop + 1 : words;
    int exp_bytes = (bytes < supply * NB) ? bytes : supply * NB;
    int ks = 0, km = 0, cyc = 0, last_fire = -1, cmd_fire = -1;
    bit done = 0, cmd_taken = 0;
    logic [15:0] tag = 16'(addr * 7 + bytes);
    while (!done && cyc < 600) begin
      @(negedge clk);
      step_lfsr();
      cmd_valid  = !cmd_taken;
      cmd_addr   = AW'(addr);
      cmd_bytes  = CW'(bytes);
      cmd_stream = strm;
      mem_ready  = gaps ? lfsr[3] : 1'b1;
      src_valid  = (ks < supply) && (gaps ? lfsr[7] : 1'b1);
      src_data   = {tag, 16'(ks)};
      src_last   = strm ? (ks == eop) : lfsr[11];
      #1;
      if (sts_valid) begin
        // R8 / R9 timing
        if (bytes == 0)
          check(cyc == cmd_fire + 1, "R9 sts cycle", cyc, cmd_fire + 1);
        else
          check(cyc == last_fire + 1, "R8 sts cycle", cyc, last_fire + 1);
        check(sts_bytes == CW'(exp_bytes), "R8/R7 sts_bytes", sts_bytes, exp_bytes);
        check(sts_err == (bytes == 0), "R9 sts_err", sts_err, bytes == 0);
        check(sts_short == (exp_bytes < bytes), "R7 sts_short", sts_short, exp_bytes < bytes);
        check(km == supply, "R5/R7 beat count", km, supply);
        done = 1;
      end
      if (cmd_taken && !done && cyc > cmd_fire)
        if (!cmd_ready) ; else check(0, "R2 cmd_ready busy", cmd_ready, 0);
      if (cmd_valid && cmd_ready) begin
        cmd_taken = 1;
        cmd_fire = cyc;
      end
      if (src_valid && src_ready) ks++;
      if (mem_valid && mem_ready) begin
        int take = (bytes - km * NB < NB) ? bytes - km * NB : NB;
        logic [NB-1:0] ebe = NB'((1 << take) - 1);
        check(mem_addr == AW'(addr + km), "R3 mem_addr", mem_addr, addr + km);
        check(mem_data == {tag, 16'(km)}, "R4 mem_data", mem_data, {tag, 16'(km)});
        check(mem_be == ebe, "R6 mem_be", mem_be, ebe);
        km++;
        last_fire = cyc;
      end
      cyc++;
    end
    if (!done) check(0, "R8 status missing", 0, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    src_valid = 1'b0;
    #1;
    check(!sts_valid && !mem_valid && cmd_ready, "R8 idle after status", sts_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    check(mem_valid == 1'b0, "R1 mem_valid", mem_valid, 0);
    check(sts_valid == 1'b0, "R1 sts_valid", sts_valid, 0);
    rst_n = 1'b1;
    for (int g = 0; g < 2; g++)
      for (int b = 0; b <= 14; b++) begin
        // R5: buffered mode, src_last toggled randomly
        run(16 * b + 3, b, 1'b0, -1, g[0]);
        // R7: stream mode, no early end and early ends
        run(900 + b, b, 1'b1, -1, g[0]);
        for (int e = 0; e < 3; e++)
          run(2000 + 8 * b + e, b, 1'b1, e, g[0]);
      end
    // R4: long pause pattern on a big transfer
    run(16'hFFF0, 40, 1'b0, -1, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule